// File: doc/BRIEF.md
# I2C Slave Front-End with 32-bit Register Addressing

This block is the serial half of a bridge from a two-wire bus to an on-chip register bus. It watches the SCL and SDA lines and finds START and STOP conditions. It responds to the device address 0000000 and then collects a 32-bit register address sent as four bytes. Write data bytes are passed out one at a time on a parallel port. For reads, it asks the downstream engine for each byte and shifts that byte back onto the bus. The downstream engine controls flow through an accept input. While accept is low, any byte that the engine would have to take is answered with a NACK.

The controller is a single state machine with these states:
- ST_IDLE: the bus is free.
- ST_DEV: device address byte.
- ST_DEV_ACK: acknowledge of the device address.
- ST_ADDR and ST_ADDR_ACK: a register address byte and its acknowledge.
- ST_WDATA and ST_WDATA_ACK: a write data byte and its acknowledge.
- ST_RDATA: shifting a read byte out.
- ST_RACK: sampling the master's acknowledge.
- ST_RDONE: waiting after a master NACK.
- ST_SKIP: a transaction that was not acknowledged, ignored until STOP or START.

The transitions are:
- A START moves from any state to ST_DEV. A STOP moves from any state to ST_IDLE.
- ST_DEV goes to ST_DEV_ACK on a match, or to ST_SKIP on a miss.
- ST_DEV_ACK goes to ST_ADDR for a write or to ST_RDATA for a read.
- ST_ADDR goes to ST_ADDR_ACK when accepted, or to ST_SKIP when refused.
- ST_ADDR_ACK goes back to ST_ADDR for the next address byte. After the fourth byte it goes to ST_WDATA.
- ST_WDATA goes to ST_WDATA_ACK when accepted, or to ST_SKIP when refused. ST_WDATA_ACK returns to ST_WDATA.
- ST_RDATA goes to ST_RACK after eight bits.
- ST_RACK goes back to ST_RDATA when the master acknowledges, or to ST_RDONE when it does not.

A register read uses two transactions joined by a repeated START. The first is a write of the device address plus the four address bytes. The second is the device address with the read bit set. The stored register address is kept across the repeated START.

Top module: `i2c_regaddr_slave`

## Requirements
- R1: While rst_n is low and in the first cycle after it is released, sda_oe_o, addr_valid_o, data_valid_o, load_o, finish_o, cancel_o and rnw_o are all 0.
- R2: Only the device address 0000000 (the upper seven bits of the first byte after START, MSB first) is acknowledged. For any other address SDA stays released, and no data_valid_o or load_o pulse follows.
- R3: The eighth bit of the device byte sets rnw_o: 0 means write and 1 means read.
- R4: In a write, the four bytes after the device address form the 32-bit register address, first byte in bits 31:24. Each byte is acknowledged while accept_i is high. Once the fourth byte is taken, reg_addr_o holds the address and addr_valid_o is 1. addr_valid_o is cleared when a new write's device address is acknowledged.
- R5: Each write data byte after the address appears on wr_data_o together with a one-cycle data_valid_o pulse and is acknowledged. Any number of consecutive bytes, four or more, are delivered in order.
- R6: If accept_i is low when a register address byte or data byte ends, SDA stays released (NACK) and no data_valid_o is produced. Every later byte is ignored and NACKed, even if accept_i rises again. The STOP that follows produces neither finish_o nor cancel_o.
- R7: In a read, load_o pulses for one cycle when the read device address is acknowledged, and again at each master ACK. Each byte is taken from rd_data_i and shifted out MSB first.
- R8: After a master NACK the slave keeps SDA released until the next STOP or START.
- R9: A STOP or repeated START gives a one-cycle finish_o pulse when it arrives after the register address is complete (with fewer than two bits of a new data byte clocked in) or during a read.
- R10: A STOP or START gives a one-cycle cancel_o pulse when it arrives before the register address is complete, or after two or more bits of a write data byte. finish_o and cancel_o are never high together.
- R11: SDA is driven only low, through sda_oe_o, and sda_oe_o changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| accept_i | input | 1 | Downstream can take the current byte |
| rd_data_i | input | 8 | Read byte from the downstream engine |
| reg_addr_o | output | 32 | Collected register address |
| addr_valid_o | output | 1 | Register address complete |
| wr_data_o | output | 8 | Last write data byte |
| data_valid_o | output | 1 | One-cycle strobe for wr_data_o |
| rnw_o | output | 1 | 1 for a read transaction |
| load_o | output | 1 | Request for the next read byte |
| finish_o | output | 1 | Transfer finished |
| cancel_o | output | 1 | Transfer aborted by the master |

## Verification
The following are checked on every cycle:
- data_valid_o and load_o are single-cycle pulses.
- Write strobes come only with a complete address and a write direction, and load only comes with a read direction.
- finish_o and cancel_o never coincide.
- SDA drive changes only while SCL is low.

Other behaviour depends on the bus sequence and only the bench scenarios can show it:
- Which device addresses are acknowledged, swept over all 128 values.
- The assembled register address and byte ordering.
- The NACK-and-ignore behaviour once accept_i drops.
- The bytes returned in a read and the release after a master NACK.
- Whether a given STOP counts as finish, cancel or neither.

// File: rtl/i2c_rs_pkg.sv
package i2c_rs_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WDATA_ACK,
        ST_RDATA,
        ST_RACK,
        ST_RDONE,
        ST_SKIP
    } state_t;

endpackage

// File: rtl/i2c_rs_sync.sv
module i2c_rs_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] pipe;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= {STAGES{RST_VAL}};
        end else begin
            pipe <= {pipe[STAGES-2:0], d_i};
        end
    end

    assign q_o = pipe[STAGES-1];

endmodule

// File: rtl/i2c_rs_cond.sv
module i2c_rs_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_rs_fsm.sv
module i2c_rs_fsm
    import i2c_rs_pkg::*;
#(
    parameter int          BYTE_W     = 8,
    parameter int          ADDR_BYTES = 4,
    parameter logic [6:0]  DEV_ADDR   = 7'b0000000,
    localparam int         ADDR_W     = BYTE_W * ADDR_BYTES,
    localparam int         CNT_W      = $clog2(BYTE_W + 1),
    localparam int         ABC_W      = $clog2(ADDR_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              accept_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic              sda_oe_o,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic              addr_valid_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              data_valid_o,
    output logic              rnw_o,
    output logic              load_o,
    output logic              finish_o,
    output logic              cancel_o
);

    state_t             state;
    state_t             nxt;
    logic [CNT_W-1:0]   bit_cnt;
    logic [BYTE_W-1:0]  sh;
    logic [BYTE_W-1:0]  tx;
    logic [ABC_W-1:0]   abyte;
    logic [ADDR_W-1:0]  addr_acc;
    logic               ack_drv;
    logic               m_ack;

    logic byte_done;
    logic dev_hit;
    logic last_abyte;
    logic early_byte;
    logic finish_zone;
    logic cancel_zone;

    assign byte_done  = (bit_cnt == CNT_W'(BYTE_W));
    assign dev_hit    = (sh[BYTE_W-1:1] == DEV_ADDR);
    assign last_abyte = (abyte == ABC_W'(ADDR_BYTES - 1));
    assign early_byte = (bit_cnt <= CNT_W'(1));

    always_comb begin
        finish_zone = 1'b0;
        cancel_zone = 1'b0;
        unique case (state)
            ST_DEV_ACK:   cancel_zone = ~rnw_o;
            ST_ADDR,
            ST_ADDR_ACK:  cancel_zone = 1'b1;
            ST_WDATA: begin
                finish_zone = early_byte;
                cancel_zone = ~early_byte;
            end
            ST_WDATA_ACK,
            ST_RDATA,
            ST_RACK,
            ST_RDONE:     finish_zone = 1'b1;
            default: begin
                finish_zone = 1'b0;
                cancel_zone = 1'b0;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        if (start_det) begin
            nxt = ST_DEV;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      nxt = ST_IDLE;
                ST_DEV:       if (scl_fall && byte_done)
                                  nxt = dev_hit ? ST_DEV_ACK : ST_SKIP;
                ST_DEV_ACK:   if (scl_fall)
                                  nxt = rnw_o ? ST_RDATA : ST_ADDR;
                ST_ADDR:      if (scl_fall && byte_done)
                                  nxt = accept_i ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK:  if (scl_fall)
                                  nxt = last_abyte ? ST_WDATA : ST_ADDR;
                ST_WDATA:     if (scl_fall && byte_done)
                                  nxt = accept_i ? ST_WDATA_ACK : ST_SKIP;
                ST_WDATA_ACK: if (scl_fall)
                                  nxt = ST_WDATA;
                ST_RDATA:     if (scl_fall && byte_done)
                                  nxt = ST_RACK;
                ST_RACK:      if (scl_fall)
                                  nxt = m_ack ? ST_RDATA : ST_RDONE;
                ST_RDONE:     nxt = ST_RDONE;
                ST_SKIP:      nxt = ST_SKIP;
                default:      nxt = ST_IDLE;
            endcase
        end
    end

    // Datapath and registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt      <= '0;
            sh           <= '0;
            tx           <= '0;
            abyte        <= '0;
            addr_acc     <= '0;
            ack_drv      <= 1'b0;
            m_ack        <= 1'b0;
            reg_addr_o   <= '0;
            addr_valid_o <= 1'b0;
            wr_data_o    <= '0;
            data_valid_o <= 1'b0;
            rnw_o        <= 1'b0;
            load_o       <= 1'b0;
            finish_o     <= 1'b0;
            cancel_o     <= 1'b0;
        end else begin
            load_o       <= 1'b0;
            data_valid_o <= 1'b0;
            finish_o     <= 1'b0;
            cancel_o     <= 1'b0;
            if (start_det || stop_det) begin
                finish_o <= finish_zone;
                cancel_o <= cancel_zone;
                bit_cnt  <= '0;
                ack_drv  <= 1'b0;
            end else begin
                unique case (state)
                    ST_DEV: begin
                        if (scl_rise) begin
                            sh      <= {sh[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end else if (scl_fall && byte_done) begin
                            ack_drv <= dev_hit;
                            if (dev_hit) begin
                                rnw_o  <= sh[0];
                                load_o <= sh[0];
                            end
                        end
                    end
                    ST_DEV_ACK: begin
                        if (scl_fall) begin
                            ack_drv <= 1'b0;
                            bit_cnt <= '0;
                            abyte   <= '0;
                            if (rnw_o) begin
                                tx <= rd_data_i;
                            end else begin
                                addr_valid_o <= 1'b0;
                            end
                        end
                    end
                    ST_ADDR: begin
                        if (scl_rise) begin
                            sh      <= {sh[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end else if (scl_fall && byte_done) begin
                            ack_drv  <= accept_i;
                            addr_acc <= {addr_acc[ADDR_W-BYTE_W-1:0], sh};
                            if (accept_i && last_abyte) begin
                                reg_addr_o   <= {addr_acc[ADDR_W-BYTE_W-1:0], sh};
                                addr_valid_o <= 1'b1;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            ack_drv <= 1'b0;
                            bit_cnt <= '0;
                            abyte   <= abyte + ABC_W'(1);
                        end
                    end
                    ST_WDATA: begin
                        if (scl_rise) begin
                            sh      <= {sh[BYTE_W-2:0], sda_s};
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end else if (scl_fall && byte_done) begin
                            ack_drv <= accept_i;
                            if (accept_i) begin
                                wr_data_o    <= sh;
                                data_valid_o <= 1'b1;
                            end
                        end
                    end
                    ST_WDATA_ACK: begin
                        if (scl_fall) begin
                            ack_drv <= 1'b0;
                            bit_cnt <= '0;
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + CNT_W'(1);
                        end else if (scl_fall && !byte_done) begin
                            tx <= {tx[BYTE_W-2:0], 1'b0};
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            m_ack  <= ~sda_s;
                            load_o <= ~sda_s;
                        end else if (scl_fall && m_ack) begin
                            tx      <= rd_data_i;
                            bit_cnt <= '0;
                        end
                    end
                    default: begin
                        ack_drv <= 1'b0;
                    end
                endcase
            end
        end
    end

    // Open-drain drive
    always_comb begin
        unique case (state)
            ST_DEV_ACK,
            ST_ADDR_ACK,
            ST_WDATA_ACK: sda_oe_o = ack_drv;
            ST_RDATA:     sda_oe_o = ~tx[BYTE_W-1];
            default:      sda_oe_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/i2c_regaddr_slave.sv
module i2c_regaddr_slave #(
    parameter int          BYTE_W      = 8,
    parameter int          ADDR_BYTES  = 4,
    parameter int          SYNC_STAGES = 2,
    parameter logic [6:0]  DEV_ADDR    = 7'b0000000,
    localparam int         ADDR_W      = BYTE_W * ADDR_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic              accept_i,
    input  logic [BYTE_W-1:0] rd_data_i,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic              addr_valid_o,
    output logic [BYTE_W-1:0] wr_data_o,
    output logic              data_valid_o,
    output logic              rnw_o,
    output logic              load_o,
    output logic              finish_o,
    output logic              cancel_o
);

    logic scl_s;
    logic sda_s;
    logic scl_rise;
    logic scl_fall;
    logic start_det;
    logic stop_det;

    i2c_rs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) scl_sync_i (
        .clk(clk), .rst_n(rst_n), .d_i(scl_i), .q_o(scl_s)
    );

    i2c_rs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sda_sync_i (
        .clk(clk), .rst_n(rst_n), .d_i(sda_i), .q_o(sda_s)
    );

    i2c_rs_cond cond_i (
        .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_rs_fsm #(
        .BYTE_W(BYTE_W), .ADDR_BYTES(ADDR_BYTES), .DEV_ADDR(DEV_ADDR)
    ) fsm_i (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .accept_i(accept_i), .rd_data_i(rd_data_i),
        .sda_oe_o(sda_oe_o), .reg_addr_o(reg_addr_o),
        .addr_valid_o(addr_valid_o), .wr_data_o(wr_data_o),
        .data_valid_o(data_valid_o), .rnw_o(rnw_o), .load_o(load_o),
        .finish_o(finish_o), .cancel_o(cancel_o)
    );

endmodule

// File: rtl/i2c_regaddr_slave_chk.sv
module i2c_regaddr_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_oe_o,
    input logic addr_valid_o,
    input logic data_valid_o,
    input logic rnw_o,
    input logic load_o,
    input logic finish_o,
    input logic cancel_o
);

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!sda_oe_o && !data_valid_o && !load_o && !finish_o && !cancel_o);
        end
    end

    // R5
    dv_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid_o |=> !data_valid_o);

    // R5
    dv_context_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid_o |-> (addr_valid_o && !rnw_o));

    // R7
    load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> !load_o);

    // R7
    load_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |-> rnw_o);

    // R10
    end_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(finish_o && cancel_o));

    // R11
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $changed(sda_oe_o) |-> !scl_i);

endmodule

bind i2c_regaddr_slave i2c_regaddr_slave_chk chk_i (.*);

// File: tb/i2c_regaddr_slave_tb.sv
module i2c_regaddr_slave_tb_top;

    localparam int Q = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        accept = 1'b1;
    logic [7:0]  rd_data = 8'h00;
    logic        sda_oe;
    logic [31:0] reg_addr;
    logic        addr_valid;
    logic [7:0]  wr_data;
    logic        data_valid;
    logic        rnw;
    logic        load;
    logic        finish;
    logic        cancel;
    logic        sda_line;

    int n_chk = 0;
    int n_fail = 0;
    int dv_n = 0;
    int ld_n = 0;
    int fin_n = 0;
    int can_n = 0;
    int oe_viol = 0;
    logic [7:0] dv_log [0:15];
    logic prev_oe = 1'b0;

    always #10 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    i2c_regaddr_slave dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .accept_i(accept), .rd_data_i(rd_data),
        .reg_addr_o(reg_addr), .addr_valid_o(addr_valid),
        .wr_data_o(wr_data), .data_valid_o(data_valid), .rnw_o(rnw),
        .load_o(load), .finish_o(finish), .cancel_o(cancel)
    );

    function automatic logic [7:0] rd_pat(int k);
        return 8'((k * 53) + 8'h9C);
    endfunction

    always @(posedge clk) begin
        prev_oe <= sda_oe;
        if (rst_n && (sda_oe != prev_oe) && scl_m) oe_viol <= oe_viol + 1;
        if (data_valid) begin
            if (dv_n < 16) dv_log[dv_n] <= wr_data;
            dv_n <= dv_n + 1;
        end
        if (load) begin
            rd_data <= rd_pat(ld_n);
            ld_n <= ld_n + 1;
        end
        if (finish) fin_n <= fin_n + 1;
        if (cancel) can_n <= can_n + 1;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; wt(Q);
        scl_m = 1'b1; wt(Q);
        sda_m = 1'b0; wt(Q);
        scl_m = 1'b0; wt(Q);
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; wt(Q);
        scl_m = 1'b1; wt(Q);
        sda_m = 1'b1; wt(2 * Q);
    endtask

    task automatic send_bit(input bit b);
        sda_m = b; wt(Q);
        scl_m = 1'b1; wt(2 * Q);
        scl_m = 1'b0; wt(Q);
    endtask

    task automatic get_bit(output bit b);
        sda_m = 1'b1; wt(Q);
        scl_m = 1'b1; wt(Q);
        b = sda_line; wt(Q);
        scl_m = 1'b0; wt(Q);
    endtask

    task automatic wr_byte(input logic [7:0] v, output bit acked);
        bit s;
        for (int i = 7; i >= 0; i--) send_bit(v[i]);
        get_bit(s);
        acked = ~s;
    endtask

    task automatic rd_byte(output logic [7:0] v, input bit give_ack);
        bit s;
        for (int i = 7; i >= 0; i--) begin
            get_bit(s);
            v[i] = s;
        end
        send_bit(~give_ack);
    endtask

    task automatic send_addr(input logic [31:0] a);
        bit ak;
        for (int i = 3; i >= 0; i--) begin
            wr_byte(a[i*8 +: 8], ak);
            chk(ak, "R4 address byte ack", ak, 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        bit ak;
        bit s;
        int base_dv, base_ld, base_fin, base_can;
        logic [7:0] rb;

        wt(3);
        chk(!sda_oe && !addr_valid && !data_valid && !load && !finish && !cancel && !rnw,
            "R1 reset outputs", {sda_oe, addr_valid, data_valid, load, finish, cancel, rnw}, 0);
        rst_n = 1'b1;
        wt(1);
        chk(!sda_oe && !addr_valid && !data_valid && !load && !finish && !cancel && !rnw,
            "R1 after release", {sda_oe, addr_valid, data_valid, load}, 0);

        // R2 sweep of every device address with the write bit
        for (int a = 0; a < 128; a++) begin
            i2c_start();
            wr_byte({7'(a), 1'b0}, ak);
            chk(ak == (a == 0), "R2 device address ack", ak, (a == 0));
            i2c_stop();
        end
        chk(dv_n == 0 && ld_n == 0, "R2 no strobes on sweep", dv_n + ld_n, 0);
        chk(can_n == 1, "R10 cancel on address-less write", can_n, 1);
        chk(fin_n == 0, "R9 no finish on sweep", fin_n, 0);

        // R4 R5 write with five data bytes
        i2c_start();
        wr_byte(8'h00, ak);
        chk(ak, "R2 match ack", ak, 1);
        chk(rnw == 1'b0, "R3 write direction", rnw, 0);
        send_addr(32'hA5C3_1E7B);
        wt(2);
        chk(addr_valid, "R4 addr_valid", addr_valid, 1);
        chk(reg_addr == 32'hA5C3_1E7B, "R4 register address", reg_addr, 32'hA5C3_1E7B);
        for (int i = 0; i < 5; i++) begin
            wr_byte(8'(i * 29 + 3), ak);
            chk(ak, "R5 data ack", ak, 1);
        end
        chk(dv_n == 5, "R5 data strobe count", dv_n, 5);
        for (int i = 0; i < 5; i++)
            chk(dv_log[i] == 8'(i * 29 + 3), "R5 data byte", dv_log[i], 8'(i * 29 + 3));
        i2c_stop();
        chk(fin_n == 1, "R9 finish after write", fin_n, 1);
        chk(can_n == 1, "R10 no cancel after write", can_n, 1);

        // R6 data byte refused
        base_dv = dv_n;
        i2c_start();
        wr_byte(8'h00, ak);
        send_addr(32'h0123_4567);
        accept = 1'b0;
        wr_byte(8'h5A, ak);
        chk(!ak, "R6 data NACK", ak, 0);
        accept = 1'b1;
        wr_byte(8'hC3, ak);
        chk(!ak, "R6 later byte ignored", ak, 0);
        chk(dv_n == base_dv, "R6 no data strobe", dv_n, base_dv);
        i2c_stop();
        chk(fin_n == 1 && can_n == 1, "R6 no end pulse", fin_n + can_n, 2);

        // R6 address byte refused
        i2c_start();
        wr_byte(8'h00, ak);
        wr_byte(8'h11, ak);
        accept = 1'b0;
        wr_byte(8'h22, ak);
        chk(!ak, "R6 address NACK", ak, 0);
        accept = 1'b1;
        chk(!addr_valid, "R4 addr_valid cleared", addr_valid, 0);
        i2c_stop();
        chk(fin_n == 1 && can_n == 1, "R6 no end pulse after address NACK", fin_n + can_n, 2);

        // R10 abort during address
        i2c_start();
        wr_byte(8'h00, ak);
        wr_byte(8'hDE, ak);
        wr_byte(8'hAD, ak);
        i2c_stop();
        chk(can_n == 2, "R10 cancel mid address", can_n, 2);

        // R10 abort mid data byte
        base_dv = dv_n;
        i2c_start();
        wr_byte(8'h00, ak);
        send_addr(32'hFFCF_0000);
        wr_byte(8'h77, ak);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        i2c_stop();
        chk(can_n == 3 && fin_n == 1, "R10 cancel mid data", can_n, 3);
        chk(dv_n == base_dv + 1, "R5 byte before abort", dv_n, base_dv + 1);

        // R7 R8 read through repeated START
        base_ld = ld_n;
        base_fin = fin_n;
        base_can = can_n;
        i2c_start();
        wr_byte(8'h00, ak);
        send_addr(32'h3C00_F0C1);
        i2c_start();
        chk(fin_n == base_fin + 1, "R9 finish on repeated START", fin_n, base_fin + 1);
        wr_byte(8'h01, ak);
        chk(ak, "R2 read address ack", ak, 1);
        chk(rnw == 1'b1, "R3 read direction", rnw, 1);
        chk(ld_n == base_ld + 1, "R7 load at read start", ld_n, base_ld + 1);
        for (int k = 0; k < 3; k++) begin
            rd_byte(rb, k < 2);
            chk(rb == rd_pat(base_ld + k), "R7 read byte", rb, rd_pat(base_ld + k));
        end
        chk(ld_n == base_ld + 3, "R7 load per master ACK", ld_n, base_ld + 3);
        for (int i = 0; i < 8; i++) begin
            get_bit(s);
            chk(s == 1'b1, "R8 SDA released after NACK", s, 1);
        end
        i2c_stop();
        chk(fin_n == base_fin + 2 && can_n == base_can, "R9 finish after read", fin_n, base_fin + 2);
        chk(reg_addr == 32'h3C00_F0C1 && addr_valid, "R4 address kept over read", reg_addr, 32'h3C00_F0C1);
        chk(oe_viol == 0, "R11 SDA drive changes only with SCL low", oe_viol, 0);
        chk(!sda_oe, "R11 released when idle", sda_oe, 0);

        report();
    end

endmodule